// File: doc/BRIEF.md
# Link Controller Interrupt Event Register

This block keeps the host-visible interrupt event word of a serial-bus link controller. Ten of its bits are sticky event flags. Each flag is raised by a single-cycle pulse from DMA, PHY or link logic, or by software through a set-write. It stays raised until software clears it with a write-one-to-clear. Two further bits are not stored. Each one is computed every cycle as the OR, over all isochronous contexts in one direction, of (context event AND context mask). The isochronous receive contexts drive one summary bit and the transmit contexts drive the other.

Software reaches the word through a plain register port. A set strobe and a clear strobe share one write-data bus. A read strobe captures the current word into a read-data register. The port has no back-pressure: every strobe is accepted in the cycle it is high. Because the word mixes stored and live bits, a read returns the live summary bits as they stood on the strobe cycle.

A bus-reset event always invalidates any earlier self-ID completion. When the bus-reset flag is set, the self-ID flag is cleared in that same cycle.

Top module: `irq_event_reg`

## Requirements
- R1: An active-low synchronous reset clears every sticky bit. The next read returns 0 when all isochronous events are inactive.
- R2: A one-cycle hardware pulse on a sticky position sets that bit, and the bit stays 1 until it is cleared. The sticky positions are 17 (bus reset), 16 (self-ID done), 9 (lock response error), 8 (posted write error), 5 (response packet received), 4 (request packet received), 3 and 2 (async receive response and request done), and 1 and 0 (async transmit response and request done).
- R3: A clear-write with a 1 in a sticky position clears that bit. A 0 in that position leaves the bit unchanged.
- R4: A set-write with a 1 in a sticky position sets that bit.
- R5: If a bit sees a set (hardware pulse or set-write) and a clear-write in the same cycle, the bit ends up 1.
- R6: In any cycle where bit 17 receives a set, bit 16 becomes 0. This holds even if a self-ID pulse arrives in the same cycle, and even if bit 17 was already 1.
- R7: Bit 7 equals the OR over receive contexts of (event AND mask). It is computed live and is not latched.
- R8: Bit 6 equals the OR over transmit contexts of (event AND mask). It is computed live and is not latched.
- R9: Bits 31:18 and 15:10 always read 0. Hardware pulses and writes aimed at those bits, or at bits 7 and 6, change nothing.
- R10: A read strobe loads the current word into `rd_data_o` at the next clock edge. The value then holds until the next read strobe. A reset sets `rd_data_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_evt_i | input | 32 | Hardware event pulses, one per bit position |
| wr_set_i | input | 1 | Set-write strobe |
| wr_clr_i | input | 1 | Clear-write strobe |
| wr_data_i | input | 32 | Write data for both write strobes |
| rd_stb_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Captured register word |
| irx_evt_i | input | CTX_N | Receive context event bits |
| irx_msk_i | input | CTX_N | Receive context mask bits |
| itx_evt_i | input | CTX_N | Transmit context event bits |
| itx_msk_i | input | CTX_N | Transmit context mask bits |

## Verification
Two pairs of functions can collide in a single cycle. A hardware set pulse can meet a software clear-write on the same bit, and a bus-reset set can meet a self-ID pulse. The bench drives each pair in one shared cycle and then reads the word back: the contested bit must be 1, and bit 16 must be 0. The same read-back is used after a bus reset that repeats while bit 17 is already set, to confirm that bit 16 is still cleared.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W    = 32;
  localparam int B_BUSRST = 17;
  localparam int B_SELFID = 16;
  localparam int B_IRX    = 7;
  localparam int B_ITX    = 6;
  localparam logic [REG_W-1:0] STICKY_MASK = 32'h0003_033F;
endpackage

// File: rtl/irq_sticky_cell.sv
module irq_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (kill_i) q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R2, R4, R5: any set without kill leaves the bit high
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !kill_i) |=> (!rst_n || q_o));
  // R3: a lone clear drops the bit
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !kill_i) |=> (!rst_n || !q_o));
  // R2: with no request the bit keeps its value
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !kill_i) |=> (!rst_n || q_o == $past(q_o)));
endmodule

// File: rtl/irq_iso_summary.sv
module irq_iso_summary #(
  parameter int CTX_N = 4
) (
  input  logic [CTX_N-1:0] evt_i,
  input  logic [CTX_N-1:0] msk_i,
  output logic             any_o
);
  logic [CTX_N-1:0] hit;
  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    assign hit[c] = evt_i[c] & msk_i[c];
  end
  assign any_o = |hit;
endmodule

// File: rtl/irq_event_reg.sv
module irq_event_reg
  import irq_evt_pkg::*;
#(
  parameter int CTX_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      hw_evt_i,
  input  logic             wr_set_i,
  input  logic             wr_clr_i,
  input  logic [31:0]      wr_data_i,
  input  logic             rd_stb_i,
  output logic [31:0]      rd_data_o,
  input  logic [CTX_N-1:0] irx_evt_i,
  input  logic [CTX_N-1:0] irx_msk_i,
  input  logic [CTX_N-1:0] itx_evt_i,
  input  logic [CTX_N-1:0] itx_msk_i
);
  logic [REG_W-1:0] set_req, clr_req, view;
  logic irx_any, itx_any;

  assign set_req = hw_evt_i | ({REG_W{wr_set_i}} & wr_data_i);
  assign clr_req = {REG_W{wr_clr_i}} & wr_data_i;

  irq_iso_summary #(.CTX_N(CTX_N)) u_irx (
    .evt_i(irx_evt_i), .msk_i(irx_msk_i), .any_o(irx_any));
  irq_iso_summary #(.CTX_N(CTX_N)) u_itx (
    .evt_i(itx_evt_i), .msk_i(itx_msk_i), .any_o(itx_any));

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      logic kill;
      if (i == B_SELFID) begin : g_kill
        assign kill = set_req[B_BUSRST];
      end else begin : g_nokill
        assign kill = 1'b0;
      end
      irq_sticky_cell u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_req[i]), .clr_i(clr_req[i]),
        .kill_i(kill), .q_o(view[i]));
    end else if (i == B_IRX) begin : g_irx
      assign view[i] = irx_any;
    end else if (i == B_ITX) begin : g_itx
      assign view[i] = itx_any;
    end else begin : g_rsvd
      assign view[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= view;
  end

  // R6: a bus-reset set leaves self-ID low after the edge
  a_r6_busrst_kills_selfid: assert property (@(posedge clk) disable iff (!rst_n)
    set_req[B_BUSRST] |=> (!rst_n || (view[B_SELFID] == 1'b0 && view[B_BUSRST])));
  // R10: the captured word is the word seen on the strobe cycle
  a_r10_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (!rst_n || rd_data_o == $past(view)));
  // R10: without a strobe the read register holds
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> (!rst_n || rd_data_o == $past(rd_data_o)));
endmodule

// File: tb/test_irq_event_reg.sv
module test_irq_event_reg;
  localparam int PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [31:0] hw;
    logic [31:0] wset;
    logic [31:0] wclr;
    logic [3:0]  rxe;
    logic [3:0]  rxm;
    logic [3:0]  txe;
    logic [3:0]  txm;
    logic [31:0] exp;
  } vec_t;

  // cumulative vectors; zero write mask means that strobe is idle
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0001, 32'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0000_0001}, // R2
    '{32'h0002_0000, 32'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0002_0001}, // R2
    '{32'h0001_0000, 32'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0003_0001}, // R2
    '{32'h0, 32'h0, 32'h0002_0000, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0001_0001}, // R3
    '{32'h0, 32'h0000_0330, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0001_0331}, // R4
    '{32'h0, 32'h0, 32'h0000_0011, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0001_0320}, // R3
    '{32'h0000_000C, 32'h0, 32'h0, 4'h2, 4'h2, 4'h0, 4'h0, 32'h0001_03AC}, // R7
    '{32'h0, 32'h0, 32'h0, 4'h2, 4'hD, 4'h8, 4'h8, 32'h0001_036C},         // R8
    '{32'hFFFC_FCC0, 32'hFFFC_FCC0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0001_032C}, // R9
    '{32'h0, 32'h0, 32'hFFFF_FFFF, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0000_0000}, // R3
    '{32'h0001_0000, 32'h0002_0000, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0002_0000}, // R6
    '{32'h0000_0002, 32'h0, 32'h0000_0002, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0002_0002}, // R5
    '{32'h0, 32'h0001_0000, 32'h0001_0000, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0003_0002}, // R5
    '{32'h0002_0000, 32'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0002_0002}, // R6
    '{32'h0, 32'h0, 32'h0, 4'h0, 4'h0, 4'h0, 4'h0, 32'h0002_0002},         // R3 zero clear
    '{32'h0, 32'h0, 32'h0, 4'h0, 4'hF, 4'h0, 4'hF, 32'h0002_0002},         // R7 R8 masks only
    '{32'h0, 32'h0, 32'h0, 4'h8, 4'h8, 4'h1, 4'h1, 32'h0002_00C2}          // R7 R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] hw_evt = '0, wr_data = '0, rd_data;
  logic wr_set = 1'b0, wr_clr = 1'b0, rd_stb = 1'b0;
  logic [3:0] irx_evt = '0, irx_msk = '0, itx_evt = '0, itx_msk = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_event_reg #(.CTX_N(4)) i_irq_event_reg (
    .clk(clk), .rst_n(rst_n), .hw_evt_i(hw_evt), .wr_set_i(wr_set),
    .wr_clr_i(wr_clr), .wr_data_i(wr_data), .rd_stb_i(rd_stb),
    .rd_data_o(rd_data), .irx_evt_i(irx_evt), .irx_msk_i(irx_msk),
    .itx_evt_i(itx_evt), .itx_msk_i(itx_msk));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of set pulses / writes; set and clear may share the cycle
  task automatic stim(input logic [31:0] hw, input logic [31:0] ws, input logic [31:0] wc);
    @(negedge clk);
    hw_evt = hw;
    wr_set = (ws != 0);
    wr_clr = (wc != 0) || (ws == 0 && hw == 0);
    wr_data = (ws != 0) ? ws : wc;
    if (ws != 0 && wc != 0) wr_data = ws | wc;
    @(negedge clk);
    hw_evt = '0; wr_set = 1'b0; wr_clr = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_read(v);
    check("R1 reset state", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      irx_evt = TBL[k].rxe; irx_msk = TBL[k].rxm;
      itx_evt = TBL[k].txe; itx_msk = TBL[k].txm;
      stim(TBL[k].hw, TBL[k].wset, TBL[k].wclr);
      do_read(v);
      check($sformatf("vector %0d (R2-R9 table)", k), v, TBL[k].exp);
    end

    // R10: no strobe, state changes, read register holds
    stim(32'h0000_0100, 32'h0, 32'h0);
    irx_evt = 4'h0; irx_msk = 4'h0; itx_evt = 4'h0; itx_msk = 4'h0;
    repeat (2) @(negedge clk);
    check("R10 hold without strobe", rd_data, 32'h0002_00C2);
    do_read(v);
    check("R10 new capture", v, 32'h0002_0102);

    // R7 live: summary follows inputs without a set pulse
    irx_evt = 4'h4; irx_msk = 4'h4;
    do_read(v);
    check("R7 live summary", v, 32'h0002_0182);
    irx_evt = 4'h0;
    do_read(v);
    check("R7 not latched", v, 32'h0002_0102);

    // R1: reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 read reg after reset", rd_data, 32'h0);
    rst_n = 1'b1;
    do_read(v);
    check("R1 sticky after reset", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule